// File: doc/BRIEF.md
# Serial Flash Write-Enable and Status Control

This block is the command-side control of a serial NOR flash slave, seen from its SPI pins. It samples chip select, serial clock and data in on the system clock. It collects each command MSB first in SPI mode 0 and keeps a status byte that holds a busy flag, a write-enable latch and a four-bit protection level. Program and erase operations are modelled only as a busy timer. The block does not hold the memory contents.

A host arms the latch with one command, then issues a modifying command. That command may be a status write, a page program, a sector erase, a block erase or a chip erase. A modifying command only acts when chip select rises exactly at the end of its frame. It only acts when the latch is armed and the device is idle. Program and erase are also refused when the protection level covers the target. The status can be read at any time, and it repeats on the data output for as long as the host keeps clocking.

Top module: `flash_wel_status`

## Requirements
- R1: After reset the status byte reads 0x00. The layout is bit 0 busy, bit 1 write-enable latch, bits 5:2 the protection level (bit 5 most significant), and bits 7:6 zero.
- R2: Opcode 0x06 in an 8-bit frame sets the latch. Opcode 0x04 in an 8-bit frame clears it.
- R3: A command is discarded unless chip select rises after exactly its bit count. The count is 8 for 0x06, 0x04, 0x60 and 0xC7, 16 for 0x01, and 32 for 0x02, 0x20 and 0xD8.
- R4: Without the latch set, 0x01, 0x02, 0x20, 0xD8, 0x60 and 0xC7 change nothing and do not raise busy.
- R5: Opcode 0x01 followed by a data byte, with the latch set, loads data bits 5:2 into the protection level and holds busy for T_SR cycles. No other command changes the protection level.
- R6: Opcodes 0x02, 0x20 and 0xD8 (opcode then 24-bit address) and 0x60/0xC7 hold busy for T_PP, T_SE, T_BE and T_CE cycles. When busy ends, busy and the latch both read 0.
- R7: A nonzero protection level N protects every address whose upper byte (address bits 23:16) is at least 256 - 2^(N-1). A program or erase aimed there is ignored and the latch stays set.
- R8: Chip erase runs only when the protection level is 0. Otherwise it is ignored and the latch stays set.
- R9: While busy, every opcode other than 0x05 is ignored. This covers latch set or clear and status write.
- R10: Opcode 0x05 returns the status byte MSB first on miso. Each bit is updated after a falling SCLK edge, starting with the falling edge that follows the opcode. The byte repeats while chip select stays low and also works while busy. miso is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the SPI pins |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial status data out of the block |

## Verification
A latch that is wrongly held or wrongly lost shows up in the very next status read as bit 1. It also shows up one cycle later as a busy flag that rises or stays low when it should not. A wrong protection level or a missed protection hit shows up as a busy flag after a refused command, or as a cleared latch. A bad busy timer shows up as bit 0 still set after the full operation time, or as a command accepted mid-operation. Each scenario therefore follows its stimulus with a repeated status read, both during and after the busy window.

// File: rtl/flash_wel_pkg.sv
package flash_wel_pkg;
  localparam int ADDR_W    = 24;
  localparam int BLK_SHIFT = 16;                  // 64 KB blocks
  localparam int BLK_W     = ADDR_W - BLK_SHIFT;
  localparam int PROT_W    = 4;

  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PGM  = 8'h02;
  localparam logic [7:0] OP_WDIS = 8'h04;
  localparam logic [7:0] OP_RDST = 8'h05;
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_SERA = 8'h20;
  localparam logic [7:0] OP_CER1 = 8'h60;
  localparam logic [7:0] OP_CER2 = 8'hC7;
  localparam logic [7:0] OP_BERA = 8'hD8;

  typedef struct packed {
    logic              wren;
    logic              wrdi;
    logic              wrsr;
    logic              pgm;
    logic              secErase;
    logic              blkErase;
    logic              chipErase;
    logic [7:0]        data;
    logic [ADDR_W-1:0] addr;
  } cmdStrobe_t;
endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_wel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  input  logic [7:0] statusByte,
  output cmdStrobe_t strb,
  output logic       miso
);
  localparam int CNT_W   = 6;
  localparam int FRAME_W = 32;

  logic [SYNC_STAGES:0]   sclkPipe;
  logic [SYNC_STAGES:0]   csPipe;
  logic [SYNC_STAGES-1:0] mosiPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclk};
      csPipe   <= {csPipe[SYNC_STAGES-1:0], csN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
    end
  end

  logic sclkS, sclkRise, sclkFall, csS, csRise, mosiS;
  assign sclkS    = sclkPipe[SYNC_STAGES-1];
  assign sclkRise = sclkS & ~sclkPipe[SYNC_STAGES];
  assign sclkFall = ~sclkS & sclkPipe[SYNC_STAGES];
  assign csS      = csPipe[SYNC_STAGES-1];
  assign csRise   = csS & ~csPipe[SYNC_STAGES];
  assign mosiS    = mosiPipe[SYNC_STAGES-1];

  logic [CNT_W-1:0]   bitCnt;
  logic [FRAME_W-1:0] shiftReg;
  logic [7:0]         opcode;
  logic [2:0]         outCnt;
  logic [7:0]         outShift;
  logic               misoR;
  logic               readActive;

  assign readActive = (bitCnt >= CNT_W'(8)) && (opcode == OP_RDST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      opcode   <= '0;
      outCnt   <= '0;
      outShift <= '0;
      misoR    <= 1'b0;
    end else if (csS) begin
      bitCnt <= '0;
      outCnt <= '0;
      misoR  <= 1'b0;
    end else begin
      if (sclkRise) begin
        shiftReg <= {shiftReg[FRAME_W-2:0], mosiS};
        if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(7)) opcode <= {shiftReg[6:0], mosiS};
      end
      if (sclkFall && readActive) begin
        if (outCnt == 3'd0) begin
          misoR    <= statusByte[7];
          outShift <= {statusByte[6:0], 1'b0};
        end else begin
          misoR    <= outShift[7];
          outShift <= {outShift[6:0], 1'b0};
        end
        outCnt <= outCnt + 1'b1;
      end
    end
  end

  // Decode happens on the cycle chip select rises, using the frame's final count.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      strb <= '0;
    end else begin
      strb <= '0;
      if (csRise) begin
        unique case (bitCnt)
          CNT_W'(8): begin
            strb.wren      <= (shiftReg[7:0] == OP_WEN);
            strb.wrdi      <= (shiftReg[7:0] == OP_WDIS);
            strb.chipErase <= (shiftReg[7:0] == OP_CER1) || (shiftReg[7:0] == OP_CER2);
          end
          CNT_W'(16): begin
            strb.wrsr <= (shiftReg[15:8] == OP_WRSR);
            strb.data <= shiftReg[7:0];
          end
          CNT_W'(32): begin
            strb.pgm      <= (shiftReg[31:24] == OP_PGM);
            strb.secErase <= (shiftReg[31:24] == OP_SERA);
            strb.blkErase <= (shiftReg[31:24] == OP_BERA);
            strb.addr     <= shiftReg[ADDR_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  assign miso = misoR;
endmodule

// File: rtl/flash_prot_check.sv
module flash_prot_check
  import flash_wel_pkg::*;
(
  input  logic [PROT_W-1:0] protLevel,
  input  logic [BLK_W-1:0]  blockIdx,
  output logic              isProt
);
  localparam int NUM_BLK = 1 << BLK_W;

  int unsigned spanBlocks;

  always_comb begin
    if (protLevel == '0) spanBlocks = 0;
    else                 spanBlocks = 32'd1 << (protLevel - 1'b1);
    isProt = (protLevel != '0) &&
             ((32'(blockIdx) + spanBlocks) >= 32'(NUM_BLK));
  end
endmodule

// File: rtl/flash_status_dp.sv
module flash_status_dp
  import flash_wel_pkg::*;
#(
  parameter int unsigned T_SR = 500,
  parameter int unsigned T_PP = 700,
  parameter int unsigned T_SE = 900,
  parameter int unsigned T_BE = 1100,
  parameter int unsigned T_CE = 1300
) (
  input  logic       clk,
  input  logic       rstN,
  input  cmdStrobe_t strb,
  output logic [7:0] statusByte
);
  localparam int unsigned MAX_A = (T_SR > T_PP) ? T_SR : T_PP;
  localparam int unsigned MAX_B = (T_SE > T_BE) ? T_SE : T_BE;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned T_MAX = (MAX_C > T_CE) ? MAX_C : T_CE;
  localparam int          TW    = $clog2(T_MAX + 1);

  logic              wip, wel;
  logic [PROT_W-1:0] protLevel;
  logic [TW-1:0]     timer;
  logic              isProt;
  logic              startOp;
  logic [TW-1:0]     loadVal;

  flash_prot_check uProt (
    .protLevel(protLevel),
    .blockIdx (strb.addr[ADDR_W-1:BLK_SHIFT]),
    .isProt   (isProt)
  );

  always_comb begin
    startOp = 1'b0;
    loadVal = '0;
    if (!wip && wel) begin
      if (strb.wrsr) begin
        startOp = 1'b1; loadVal = TW'(T_SR - 1);
      end else if (strb.pgm && !isProt) begin
        startOp = 1'b1; loadVal = TW'(T_PP - 1);
      end else if (strb.secErase && !isProt) begin
        startOp = 1'b1; loadVal = TW'(T_SE - 1);
      end else if (strb.blkErase && !isProt) begin
        startOp = 1'b1; loadVal = TW'(T_BE - 1);
      end else if (strb.chipErase && (protLevel == '0)) begin
        startOp = 1'b1; loadVal = TW'(T_CE - 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wip       <= 1'b0;
      wel       <= 1'b0;
      protLevel <= '0;
      timer     <= '0;
    end else if (wip) begin
      if (timer == '0) begin
        wip <= 1'b0;
        wel <= 1'b0;
      end else begin
        timer <= timer - 1'b1;
      end
    end else begin
      if (strb.wren) wel <= 1'b1;
      if (strb.wrdi) wel <= 1'b0;
      if (strb.wrsr && wel) protLevel <= strb.data[5:2];
      if (startOp) begin
        wip   <= 1'b1;
        timer <= loadVal;
      end
    end
  end

  assign statusByte = {2'b00, protLevel, wel, wip};
endmodule

// File: rtl/flash_wel_status.sv
module flash_wel_status
  import flash_wel_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned T_SR = 500,
  parameter int unsigned T_PP = 700,
  parameter int unsigned T_SE = 900,
  parameter int unsigned T_BE = 1100,
  parameter int unsigned T_CE = 1300
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic mosi,
  output logic miso
);
  cmdStrobe_t cmdStrb;
  logic [7:0] statusByte;

  flash_cmd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sclk      (sclk),
    .mosi      (mosi),
    .statusByte(statusByte),
    .strb      (cmdStrb),
    .miso      (miso)
  );

  flash_status_dp #(
    .T_SR(T_SR), .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE), .T_CE(T_CE)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (cmdStrb),
    .statusByte(statusByte)
  );
endmodule

// File: rtl/flash_wel_status_chk.sv
module flash_wel_status_chk
  import flash_wel_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       miso,
  input cmdStrobe_t strb,
  input logic [7:0] statusByte
);
  AST_BUSY_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[0]) |-> $past(statusByte[1])); // R4

  AST_DONE_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[0]) |-> !statusByte[1]); // R6

  AST_PROT_ONLY_BY_WRSR: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusByte[5:2]) |-> $past(strb.wrsr)); // R5

  AST_CHIP_ERASE_UNPROT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.chipErase) && $rose(statusByte[0])) |-> ($past(statusByte[5:2]) == 4'd0)); // R8

  AST_BUSY_FREEZES_STATE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusByte[0]) && statusByte[0]) |-> $stable(statusByte[5:1])); // R9

  AST_MISO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3) && $past(csN, 4)) |-> !miso); // R10
endmodule

bind flash_wel_status flash_wel_status_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .miso      (miso),
  .strb      (cmdStrb),
  .statusByte(statusByte)
);

// File: tb/tb_flash_wel_status.sv
module tb_flash_wel_status;
  import flash_wel_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  always #10 clk = ~clk;   // 50 MHz

  flash_wel_status dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  localparam int HALF = 8;
  localparam int IDLE_WAIT = 1500;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  logic [7:0] gotByte;
  event byteDone;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitXfer(input logic b, output logic r);
    sclk = 1'b0;
    mosi = b;
    waitClk(HALF);
    r = miso;
    sclk = 1'b1;
    waitClk(HALF);
  endtask

  task automatic frameStart();
    waitClk(4);
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic frameEnd();
    sclk = 1'b0;
    waitClk(HALF);
    csN = 1'b1;
    waitClk(12);
  endtask

  task automatic sendBits(input logic [31:0] w, input int n);
    logic r;
    frameStart();
    for (int i = n - 1; i >= 0; i--) bitXfer(w[i], r);
    frameEnd();
  endtask

  // Driver: pushes expected bytes, then clocks out the status read.
  task automatic readStatus(input logic [7:0] exp, input int reps, input string req);
    logic r;
    logic [7:0] b;
    for (int k = 0; k < reps; k++) expQ.push_back('{exp, req});
    frameStart();
    for (int i = 7; i >= 0; i--) bitXfer(OP_RDST[i], r);
    for (int k = 0; k < reps; k++) begin
      for (int i = 7; i >= 0; i--) begin
        bitXfer(1'b0, r);
        b[i] = r;
      end
      gotByte = b;
      ->byteDone;
    end
    frameEnd();
  endtask

  // Monitor: pops one expected item per produced byte.
  initial begin
    expItem_t it;
    forever begin
      @(byteDone);
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected byte: actual=%02h expected=none", gotByte);
      end else begin
        it = expQ.pop_front();
        if (gotByte !== it.exp) begin
          errors++;
          $display("FAIL %s status: actual=%02h expected=%02h", it.req, gotByte, it.exp);
        end
      end
    end
  end

  task automatic checkIdleMiso(input string req);
    checks++;
    if (miso !== 1'b0) begin
      errors++;
      $display("FAIL %s idle miso: actual=%b expected=0", req, miso);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    waitClk(150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    waitClk(10);
    rstN = 1'b1;
    waitClk(10);

    // R1: reset state
    readStatus(8'h00, 1, "R1");
    checkIdleMiso("R10");

    // R2: latch set and clear
    sendBits(32'h06, 8);
    readStatus(8'h02, 1, "R2");
    sendBits(32'h04, 8);
    readStatus(8'h00, 1, "R2");

    // R3: frame length must match exactly
    sendBits(32'h03, 7);
    readStatus(8'h00, 1, "R3");
    sendBits({8'h06, 1'b0}, 9);
    readStatus(8'h00, 1, "R3");
    sendBits(32'h06, 8);
    sendBits({8'h04, 4'h0}, 12);
    readStatus(8'h02, 1, "R3");
    sendBits(32'h04, 8);

    // R4: no latch, no effect
    sendBits({8'h01, 8'h3C}, 16);
    readStatus(8'h00, 1, "R4");
    sendBits({8'h20, 24'h000000}, 32);
    readStatus(8'h00, 1, "R4");
    sendBits(32'hC7, 8);
    readStatus(8'h00, 1, "R4");

    // R5: status write, level 2; R10 repeated read while busy
    sendBits(32'h06, 8);
    sendBits({8'h01, 8'h08}, 16);
    readStatus(8'h0B, 2, "R5");
    waitClk(IDLE_WAIT);
    readStatus(8'h08, 1, "R5");

    // R7: level 2 protects blocks FE and FF
    sendBits(32'h06, 8);
    sendBits({8'h20, 24'hFF0000}, 32);
    readStatus(8'h0A, 1, "R7");
    sendBits({8'h20, 24'hFE1234}, 32);
    readStatus(8'h0A, 1, "R7");
    sendBits({8'h20, 24'hFDFFFF}, 32);
    readStatus(8'h0B, 1, "R6");
    // R9: ignored while busy
    sendBits(32'h04, 8);
    sendBits({8'h01, 8'h3C}, 16);
    readStatus(8'h0B, 1, "R9");
    waitClk(IDLE_WAIT);
    readStatus(8'h08, 1, "R6");

    // R8: chip erase refused with nonzero level
    sendBits(32'h06, 8);
    sendBits(32'h60, 8);
    readStatus(8'h0A, 1, "R8");
    sendBits({8'h01, 8'h00}, 16);
    readStatus(8'h03, 1, "R5");
    waitClk(IDLE_WAIT);
    readStatus(8'h00, 1, "R5");
    sendBits(32'h06, 8);
    sendBits(32'hC7, 8);
    readStatus(8'h03, 1, "R8");
    waitClk(IDLE_WAIT);
    readStatus(8'h00, 1, "R8");
    sendBits(32'h06, 8);
    sendBits(32'h60, 8);
    readStatus(8'h03, 1, "R8");
    waitClk(IDLE_WAIT);
    readStatus(8'h00, 1, "R8");

    // R6: program and block erase
    sendBits(32'h06, 8);
    sendBits({8'h02, 24'h000100}, 32);
    readStatus(8'h03, 1, "R6");
    waitClk(IDLE_WAIT);
    readStatus(8'h00, 1, "R6");
    sendBits(32'h06, 8);
    sendBits({8'hD8, 24'h7F0000}, 32);
    readStatus(8'h03, 1, "R6");
    waitClk(IDLE_WAIT);
    readStatus(8'h00, 1, "R6");

    // R7: level 1 protects block FF only
    sendBits(32'h06, 8);
    sendBits({8'h01, 8'h04}, 16);
    waitClk(IDLE_WAIT);
    sendBits(32'h06, 8);
    sendBits({8'h02, 24'hFF0000}, 32);
    readStatus(8'h06, 1, "R7");
    sendBits({8'h02, 24'hFEFFFF}, 32);
    readStatus(8'h07, 1, "R7");
    waitClk(IDLE_WAIT);
    readStatus(8'h04, 1, "R7");

    // R7: level 15 protects everything
    sendBits(32'h06, 8);
    sendBits({8'h01, 8'h3C}, 16);
    waitClk(IDLE_WAIT);
    readStatus(8'h3C, 1, "R5");
    sendBits(32'h06, 8);
    sendBits({8'hD8, 24'h000000}, 32);
    readStatus(8'h3E, 1, "R7");
    sendBits({8'h02, 24'h000000}, 32);
    readStatus(8'h3E, 3, "R10");

    checkIdleMiso("R10");
    waitClk(10);
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R10 missing bytes: actual=%0d left expected=0", expQ.size());
    end
    finishRun();
  end
endmodule